// File: doc/BRIEF.md
# Serial Transceiver with In-Byte Parity

This block is a full-duplex asynchronous serial port: a transmitter and a receiver share one programmable bit-rate generator and sit behind a small register bus. Each frame has one low start bit, eight data bits least significant first, and one high stop bit. Software writes a byte to start a transmission and reads received bytes from the same address. Status reports a received byte, an ongoing transmission and a parity error.

Parity is optional and stays inside the eight-bit frame. When it is enabled, the transmitter overwrites the top data bit with a parity bit computed over the lower seven bits. The receiver checks all eight received bits against the selected polarity. A parity error latches a status flag, and it can drive the interrupt output. A power-off bit in the control register holds the rate generator, transmitter and receiver in their reset state.

The bit period is sixteen oversampling ticks. The tick period is a prescale factor times a power of two. The receiver decides each bit by a majority vote over three samples taken at the middle of the bit.

Top module: `msbpar_uart`

## Requirements
- R1: After reset `txd` is high, `irq` is low, and a read of each of the four registers returns zero. The addresses are 0 data, 1 status, 2 control and 3 rate.
- R2: The rate register holds a divider exponent in bits [2:0] and a prescale select in bits [4:3]. Prescale selects 0, 1, 2 and 3 give factors 1, 3, 4 and 13. One bit on `txd` lasts 16 × factor × 2^exponent clocks.
- R3: With control at zero, a byte written to address 0 is sent unchanged: a low start bit, bits 0..7 in order, then a high stop bit. A received frame is returned at address 0 and sets status bit 1. A data read clears status bit 1. Status bit 2 is high while a transmission is in progress.
- R4: With control bit 1 (parity on) set, the transmitted bit 7 is replaced by a parity bit computed over bits 6..0. If control bit 2 is 0 the parity is even, so the eight bits hold an even number of ones. If control bit 2 is 1 the parity is odd.
- R5: With parity on, the receiver checks all eight received bits against the selected polarity, and a mismatch sets status bit 0. The received byte, including the parity bit in bit 7, is still stored. A frame with matching parity leaves status bit 0 clear.
- R6: `irq` is high exactly while status bit 0 and control bit 3 (parity interrupt enable) are both set.
- R7: Status bit 0 is cleared only by a read of status that finds it set, followed by a read of data. A data read without that earlier status read leaves the flag set.
- R8: While control bit 0 (power off) is set:
  - `txd` stays high, and a frame in progress is abandoned.
  - Writes to data start no frame.
  - Incoming frames are ignored, so status bit 1 and the data register stay unchanged.
- R9: The receiver takes the majority of three samples at the middle of each bit. A one-clock glitch inside a bit does not change the received value. A low pulse on the idle line shorter than half a bit is rejected as a false start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; its side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Parity error interrupt |

## Verification
The bench builds the block with eight data bits, sixteen ticks per bit and a three-bit divider exponent. With the fastest rate setting a frame takes only 160 clocks. At that rate, looping `txd` back to `rxd` covers all 256 byte values with parity off and 128 values each with even and odd parity. Bit periods are measured for every rate setting except the four slowest 13-factor ones, and each measurement is compared with 16 × factor × 2^exponent. Frames driven directly from the bench inject glitches, false starts and wrong parity bits.

// File: rtl/msbpar_uart_pkg.sv
package msbpar_uart_pkg;

    // control register, bit 0 is the lowest field
    typedef struct packed {
        logic perr_ie;   // bit 3
        logic par_odd;   // bit 2
        logic par_en;    // bit 1
        logic off;       // bit 0
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_BAUD = 2'd3
    } reg_addr_e;

    // prescale factor chosen by the two-bit select field
    function automatic logic [3:0] pre_factor(input logic [1:0] sel);
        case (sel)
            2'd0:    pre_factor = 4'd1;
            2'd1:    pre_factor = 4'd3;
            2'd2:    pre_factor = 4'd4;
            default: pre_factor = 4'd13;
        endcase
    endfunction

endpackage

// File: rtl/msbpar_baud.sv
module msbpar_baud
    import msbpar_uart_pkg::*;
#(
    parameter int DIV_W = 3,
    localparam int CNT_W = 4 + (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       pre_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = CNT_W'(pre_factor(pre_sel)) << div_sel;
        st_d   = st_q;
        if (!en) begin
            st_d = '0;
        end else if (st_q.cnt >= period - CNT_W'(1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R8: a powered-off generator produces no tick
    assert_off_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick_o);

endmodule

// File: rtl/msbpar_tx.sv
module msbpar_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    localparam int FRAME_W = DATA_W + 2,
    localparam int BIT_W   = $clog2(FRAME_W),
    localparam int OVS_W   = $clog2(OVS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              tx_o,
    output logic              busy_o
);

    typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;

    typedef struct packed {
        tx_state_e          state;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   bit_idx;
        logic [OVS_W-1:0]   ovs;
        logic               tx;
    } state_t;

    state_t st_d, st_q;
    logic [DATA_W-1:0] byte_out;

    always_comb begin
        byte_out = data;
        if (par_en) byte_out[DATA_W-1] = par_odd ^ (^data[DATA_W-2:0]);

        st_d = st_q;
        if (!en) begin
            st_d    = '0;
            st_d.tx = 1'b1;
        end else begin
            case (st_q.state)
                TX_IDLE: begin
                    if (start) begin
                        st_d.state = TX_WAIT;
                        st_d.frame = {1'b1, byte_out, 1'b0};
                    end
                end
                TX_WAIT: begin
                    if (tick) begin
                        st_d.state   = TX_SEND;
                        st_d.bit_idx = '0;
                        st_d.ovs     = '0;
                        st_d.tx      = st_q.frame[0];
                    end
                end
                default: begin
                    if (tick) begin
                        if (st_q.ovs == OVS_W'(OVS - 1)) begin
                            st_d.ovs = '0;
                            if (st_q.bit_idx == BIT_W'(FRAME_W - 1)) begin
                                st_d.state = TX_IDLE;
                                st_d.tx    = 1'b1;
                            end else begin
                                st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                                st_d.tx      = st_q.frame[st_q.bit_idx + BIT_W'(1)];
                            end
                        end else begin
                            st_d.ovs = st_q.ovs + OVS_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.tx <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_o   = st_q.tx;
    assign busy_o = (st_q.state != TX_IDLE);

    // R2: the line only moves on an oversampling tick
    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick |=> $stable(tx_o));

    // R3: an idle transmitter keeps the line high
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

endmodule

// File: rtl/msbpar_rx.sv
module msbpar_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    localparam int BIT_W = $clog2(DATA_W + 2),
    localparam int OVS_W = $clog2(OVS),
    localparam int MID   = OVS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rx_i,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done_o,
    output logic              bad_par_o,
    output logic [DATA_W-1:0] data_o
);

    typedef enum logic {RX_IDLE, RX_RECV} rx_state_e;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [OVS_W-1:0]  ovs;
        logic [BIT_W-1:0]  bit_idx;
        logic [1:0]        vote;
        logic [DATA_W-1:0] shreg;
        logic              done;
        logic              bad;
    } state_t;

    state_t st_d, st_q;
    logic       sample;
    logic [1:0] vote_n;
    logic       bit_val;

    always_comb begin
        sample  = st_q.sync[1];
        vote_n  = st_q.vote + {1'b0, sample};
        bit_val = vote_n[1];

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.bad  = 1'b0;
        st_d.sync = {st_q.sync[0], rx_i};

        if (!en) begin
            st_d      = '0;
            st_d.sync = 2'b11;
        end else if (tick) begin
            case (st_q.state)
                RX_IDLE: begin
                    if (!sample) begin
                        st_d.state   = RX_RECV;
                        st_d.ovs     = OVS_W'(1);
                        st_d.bit_idx = '0;
                        st_d.vote    = '0;
                    end
                end
                default: begin
                    if (st_q.ovs >= OVS_W'(MID - 1) && st_q.ovs <= OVS_W'(MID + 1))
                        st_d.vote = vote_n;

                    if (st_q.ovs == OVS_W'(OVS - 1)) begin
                        st_d.ovs     = '0;
                        st_d.vote    = '0;
                        st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                    end else begin
                        st_d.ovs = st_q.ovs + OVS_W'(1);
                    end

                    if (st_q.ovs == OVS_W'(MID + 1)) begin
                        if (st_q.bit_idx == '0) begin
                            // false start: line back high at mid-bit
                            if (bit_val) st_d.state = RX_IDLE;
                        end else if (st_q.bit_idx <= BIT_W'(DATA_W)) begin
                            st_d.shreg = {bit_val, st_q.shreg[DATA_W-1:1]};
                        end else begin
                            st_d.state = RX_IDLE;
                            if (bit_val) begin
                                st_d.done = 1'b1;
                                st_d.bad  = par_en & ((^st_q.shreg) ^ par_odd);
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign bad_par_o = st_q.bad;
    assign data_o    = st_q.shreg;

    // R8: no frame completes while the cell is off
    assert_off_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done_o);

    // R5: a parity error is only flagged together with a finished frame
    assert_bad_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_par_o |-> done_o);

endmodule

// File: rtl/msbpar_uart.sv
module msbpar_uart
    import msbpar_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [1:0]        pre;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rxbuf;
        logic              full;
        logic              perr;
        logic              armed;
    } regs_t;

    regs_t rg_d, rg_q;

    logic              tick, tx_busy, tx_start, cell_en;
    logic              rx_done, rx_bad;
    logic [DATA_W-1:0] rx_data;

    assign cell_en  = !rg_q.ctrl.off;
    assign tx_start = bus_wr && (bus_addr == REG_DATA) && cell_en;

    msbpar_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cell_en),
        .pre_sel (rg_q.pre),
        .div_sel (rg_q.div),
        .tick_o  (tick)
    );

    msbpar_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cell_en),
        .tick    (tick),
        .start   (tx_start),
        .data    (bus_wdata),
        .par_en  (rg_q.ctrl.par_en),
        .par_odd (rg_q.ctrl.par_odd),
        .tx_o    (txd),
        .busy_o  (tx_busy)
    );

    msbpar_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cell_en),
        .tick      (tick),
        .rx_i      (rxd),
        .par_en    (rg_q.ctrl.par_en),
        .par_odd   (rg_q.ctrl.par_odd),
        .done_o    (rx_done),
        .bad_par_o (rx_bad),
        .data_o    (rx_data)
    );

    always_comb begin
        rg_d = rg_q;

        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL: rg_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                REG_BAUD: begin
                    rg_d.pre = bus_wdata[DIV_W+1:DIV_W];
                    rg_d.div = bus_wdata[DIV_W-1:0];
                end
                default: ;
            endcase
        end

        if (bus_rd && bus_addr == REG_STAT && rg_q.perr)
            rg_d.armed = 1'b1;

        if (bus_rd && bus_addr == REG_DATA) begin
            rg_d.full = 1'b0;
            if (rg_q.armed) begin
                rg_d.perr  = 1'b0;
                rg_d.armed = 1'b0;
            end
        end

        // a new frame wins over a clearing read in the same cycle
        if (rx_done && cell_en) begin
            rg_d.rxbuf = rx_data;
            rg_d.full  = 1'b1;
            if (rx_bad) rg_d.perr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = rg_q.rxbuf;
            REG_STAT: bus_rdata = {{(DATA_W-3){1'b0}}, tx_busy, rg_q.full, rg_q.perr};
            REG_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, rg_q.ctrl};
            default:  bus_rdata = {{(DATA_W-DIV_W-2){1'b0}}, rg_q.pre, rg_q.div};
        endcase
    end

    assign irq = rg_q.perr & rg_q.ctrl.perr_ie;

    // R8: a powered-off cell drives the line high
    assert_off_tx_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.ctrl.off |=> txd);

    // R3: the received byte only changes when a frame completes
    assert_rxbuf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rg_q.rxbuf));

    // R5: a bad frame latches the parity error flag
    assert_perr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_bad && cell_en |=> rg_q.perr);

    // R7: the flag only drops after an armed data read
    assert_perr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rg_q.perr) |-> $past(bus_rd && bus_addr == REG_DATA && rg_q.armed));

endmodule

// File: tb/msbpar_uart_bench.sv
`timescale 1ns/100ps
module msbpar_uart_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       txd, irq;
    logic       loop_en = 1'b1;
    logic       rx_drv = 1'b1;
    logic       rxd;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] last_rx = '0;

    always #2.5 clk = ~clk;

    assign rxd = loop_en ? txd : rx_drv;

    msbpar_uart u_msbpar_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd),
        .rxd       (rxd),
        .irq       (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_tx_idle();
        logic [7:0] s;
        do bus_read(2'd1, s); while (s[2]);
    endtask

    function automatic int fac(input int p);
        case (p)
            0: fac = 1;
            1: fac = 3;
            2: fac = 4;
            default: fac = 13;
        endcase
    endfunction

    // frame at the fastest rate: 16 clocks per bit
    task automatic drive_frame(input logic [7:0] b, input bit glitch);
        logic [9:0] f;
        f = {1'b1, b, 1'b0};
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                rx_drv = (glitch && c == 8) ? ~f[k] : f[k];
            end
        end
        @(negedge clk);
        rx_drv = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic loop_frame(input string tag, input logic [7:0] sent, input logic [7:0] exp);
        logic [7:0] v;
        bus_write(2'd0, sent);
        wait_tx_idle();
        bus_read(2'd1, v);
        check({tag, " status"}, v[1:0], 2'b10);
        bus_read(2'd0, v);
        check({tag, " data"}, v, exp);
        last_rx = v;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 txd", txd, 1);
        check("R1 irq", irq, 0);
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], v);
            check("R1 reg", v, 0);
        end

        // R2: bit period per rate setting; R8 abort by power-off
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 8; d++) begin
                if (p == 3 && d > 3) continue;
                bus_write(2'd3, {3'b0, p[1:0], d[2:0]});
                bus_write(2'd0, 8'hFF);
                while (txd) @(negedge clk);
                cnt = 0;
                while (!txd) begin cnt++; @(negedge clk); end
                check("R2 bit period", cnt, 16 * fac(p) * (1 << d));
                bus_write(2'd2, 8'h01);
                @(negedge clk);
                check("R8 abort txd", txd, 1);
                bus_read(2'd1, v);
                check("R8 abort busy", v[2], 0);
                bus_write(2'd2, 8'h00);
            end
        end
        bus_write(2'd3, 8'h00);
        bus_read(2'd0, v);

        // R3: all bytes, parity off
        for (int i = 0; i < 256; i++)
            loop_frame("R3", i[7:0], i[7:0]);

        // R4 even parity in bit 7
        bus_write(2'd2, 8'h02);
        for (int i = 0; i < 128; i++)
            loop_frame("R4 even", {i[0] ^ i[1], i[6:0]}, {^i[6:0], i[6:0]});

        // R4 odd parity in bit 7
        bus_write(2'd2, 8'h06);
        for (int i = 0; i < 128; i++)
            loop_frame("R4 odd", {i[0], i[6:0]}, {~^i[6:0], i[6:0]});

        // R9: glitches and a false start
        bus_write(2'd2, 8'h00);
        loop_en = 1'b1;
        @(negedge clk);
        loop_en = 1'b0;
        drive_frame(8'hA5, 1'b1);
        bus_read(2'd1, v);
        check("R9 glitch full", v[1], 1);
        bus_read(2'd0, v);
        check("R9 glitch data", v, 8'hA5);
        last_rx = v;
        @(negedge clk); rx_drv = 1'b0;
        @(negedge clk); rx_drv = 1'b1;
        repeat (40) @(negedge clk);
        bus_read(2'd1, v);
        check("R9 false start", v[1], 0);

        // R5/R6/R7: bad even parity
        bus_write(2'd2, 8'h02);
        drive_frame(8'h01, 1'b0);
        check("R6 irq masked", irq, 0);
        bus_write(2'd2, 8'h0A);
        check("R6 irq raised", irq, 1);
        bus_read(2'd0, v);
        check("R5 data kept", v, 8'h01);
        check("R7 no clear without status read", irq, 1);
        bus_read(2'd1, v);
        check("R5 perr set", v[0], 1);
        bus_read(2'd0, v);
        bus_read(2'd1, v);
        check("R7 cleared", v[0], 0);
        check("R7 irq low", irq, 0);
        // R5: good even parity frame
        drive_frame(8'h81, 1'b0);
        bus_read(2'd1, v);
        check("R5 good parity", v[1:0], 2'b10);
        bus_read(2'd0, v);
        check("R5 good data", v, 8'h81);
        last_rx = v;
        // R5: bad odd parity
        bus_write(2'd2, 8'h06);
        drive_frame(8'h03, 1'b0);
        bus_read(2'd1, v);
        check("R5 odd mismatch", v[0], 1);
        bus_read(2'd0, v);
        last_rx = v;

        // R8: power off
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, 8'h55);
        bad = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (!txd) bad++;
        end
        check("R8 txd idle", bad, 0);
        drive_frame(8'h3C, 1'b0);
        bus_read(2'd1, v);
        check("R8 no busy no full", v[2:1], 0);
        bus_read(2'd0, v);
        check("R8 data unchanged", v, last_rx);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule